// File: doc/BRIEF.md
# Fetch Address Sequencer with One-Instruction Branch Shadow

This block owns the program counter of a 32-bit RISC core in which every control transfer is followed by exactly one shadow instruction. Each cycle it presents a fetch address. When the decode stage reports that the instruction now issuing is a jump or a branch, the block records the target and whether the transfer is taken. It does not change course at once. The next sequential word always issues first, as the shadow instruction. Only after that word has been accepted does the fetch address move to the target, or continue in order when the branch is not taken.

An instruction issues in a cycle where `fetch_ready` is high. A low `fetch_ready` stalls the sequencer, and it then keeps both the address and the recorded redirect. Every issued instruction comes with an `in_slot` flag, so that later exception logic can restart at the transfer rather than at the shadow instruction. Three error flags are raised for the issuing instruction:
- a control transfer inside a shadow position,
- a 16-bit compact instruction in the shadow of an indirect jump,
- a taken target whose two low bits are not zero.

Top module: `pc_slot_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next value of `fetch_addr` is the parameter `RESET_VEC`, `in_slot` is 0 and no redirect is held.
- R2: An accepted instruction that is not in a shadow position advances `fetch_addr` by 4 on the following edge, whether or not it is a control transfer.
- R3: With `fetch_ready` low, `fetch_addr`, `in_slot` and the recorded redirect keep their values, and all error outputs are 0.
- R4: The instruction accepted directly after an accepted control transfer is at the transfer's address plus 4, and it issues with `in_slot` = 1.
- R5: After the shadow instruction is accepted, `fetch_addr` becomes the recorded target with bits [1:0] forced to 0 if the transfer was taken. If it was not taken, `fetch_addr` becomes the shadow address plus 4.
- R6: `in_slot` is 1 only for the single instruction that follows a control transfer. The instruction after the shadow issues with `in_slot` = 0.
- R7: A control transfer (`cti_valid`) accepted while `in_slot` = 1 raises `err_slot_cti` in that cycle. Its target and taken bit are ignored, and the earlier redirect still applies.
- R8: `err_compact` is 1 exactly when an accepted shadow instruction has `insn_compact` = 1 and its transfer had `cti_indirect` = 1. A compact instruction in the shadow of a direct transfer, or outside a shadow, gives 0.
- R9: `err_align` is 1 when a shadow instruction is accepted whose transfer was taken and had a target with bits [1:0] not equal to 0. A not-taken transfer with such a target gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_ready | input | 1 | The instruction at `fetch_addr` issues this cycle |
| cti_valid | input | 1 | The issuing instruction is a jump or branch |
| cti_taken | input | 1 | The branch condition resolved as taken (jumps set 1) |
| cti_indirect | input | 1 | The transfer is a register-indirect jump |
| cti_target | input | 32 | Byte address of the transfer target |
| insn_compact | input | 1 | The issuing instruction is a 16-bit compact encoding |
| fetch_addr | output | 32 | Current fetch address |
| in_slot | output | 1 | The issuing instruction occupies a shadow position |
| err_slot_cti | output | 1 | Control transfer found in a shadow position |
| err_compact | output | 1 | Compact instruction in the shadow of an indirect jump |
| err_align | output | 1 | Taken target is not word aligned |

## Verification
The error flags and `in_slot` describe the instruction issuing now. They are valid in the same cycle as `fetch_ready` and the decode inputs. `fetch_addr` changes one edge after each accepted issue. A taken target appears two accepted issues after its transfer, however many stall cycles come in between. The scoreboard lines up with this by pushing one expected record per driven cycle, holding the address, shadow flag and error flags due for that cycle. It compares them in the low clock phase once the inputs have settled, so each result is checked in the cycle it is due.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int unsigned PC_W       = 32;
    localparam int unsigned INSN_BYTES = 4;
    localparam int unsigned ALIGN_BITS = 2;

    typedef logic [PC_W-1:0] addr_t;

    // recorded control transfer awaiting its shadow instruction
    typedef struct packed {
        logic  valid;
        logic  taken;
        logic  indirect;
        addr_t target;
    } redir_t;

    typedef struct packed {
        logic slot_cti;
        logic compact;
        logic align;
    } err_t;

    function automatic addr_t word_floor(input addr_t a);
        return {a[PC_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    endfunction

    function automatic logic is_misaligned(input addr_t a);
        return |a[ALIGN_BITS-1:0];
    endfunction

endpackage

// File: rtl/pcseq_redirect_reg.sv
module pcseq_redirect_reg
    import pcseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fetch_ready,
    input  logic   cti_valid,
    input  logic   cti_taken,
    input  logic   cti_indirect,
    input  addr_t  cti_target,
    output redir_t pend_q
);

    redir_t pend_d;

    always_comb begin
        pend_d = pend_q;
        if (fetch_ready) begin
            if (pend_q.valid) begin
                // shadow instruction consumes the redirect; any transfer here is dropped
                pend_d = '0;
            end else if (cti_valid) begin
                pend_d.valid    = 1'b1;
                pend_d.taken    = cti_taken;
                pend_d.indirect = cti_indirect;
                pend_d.target   = cti_target;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

endmodule

// File: rtl/pcseq_next_pc.sv
module pcseq_next_pc
    import pcseq_pkg::*;
#(
    parameter addr_t RESET_VEC = 32'h0000_1000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   fetch_ready,
    input  redir_t pend_q,
    output addr_t  pc_q
);

    addr_t seq_pc;
    addr_t pc_d;

    assign seq_pc = pc_q + PC_W'(INSN_BYTES);

    always_comb begin
        pc_d = pc_q;
        if (fetch_ready) begin
            if (pend_q.valid && pend_q.taken) pc_d = word_floor(pend_q.target);
            else                              pc_d = seq_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_VEC;
        else     pc_q <= pc_d;
    end

endmodule

// File: rtl/pcseq_slot_check.sv
module pcseq_slot_check
    import pcseq_pkg::*;
(
    input  logic   fetch_ready,
    input  redir_t pend_q,
    input  logic   cti_valid,
    input  logic   insn_compact,
    output err_t   err
);

    logic shadow;

    assign shadow = fetch_ready && pend_q.valid;

    always_comb begin
        err.slot_cti = shadow && cti_valid;
        err.compact  = shadow && pend_q.indirect && insn_compact;
        err.align    = shadow && pend_q.taken && is_misaligned(pend_q.target);
    end

endmodule

// File: rtl/pc_slot_seq.sv
module pc_slot_seq
    import pcseq_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch_ready,
    input  logic        cti_valid,
    input  logic        cti_taken,
    input  logic        cti_indirect,
    input  logic [31:0] cti_target,
    input  logic        insn_compact,
    output logic [31:0] fetch_addr,
    output logic        in_slot,
    output logic        err_slot_cti,
    output logic        err_compact,
    output logic        err_align
);

    redir_t pend_q;
    addr_t  pc_q;
    err_t   err;

    pcseq_redirect_reg u_redir (
        .clk          (clk),
        .rst          (rst),
        .fetch_ready  (fetch_ready),
        .cti_valid    (cti_valid),
        .cti_taken    (cti_taken),
        .cti_indirect (cti_indirect),
        .cti_target   (cti_target),
        .pend_q       (pend_q)
    );

    pcseq_next_pc #(.RESET_VEC(RESET_VEC)) u_pc (
        .clk         (clk),
        .rst         (rst),
        .fetch_ready (fetch_ready),
        .pend_q      (pend_q),
        .pc_q        (pc_q)
    );

    pcseq_slot_check u_chk (
        .fetch_ready  (fetch_ready),
        .pend_q       (pend_q),
        .cti_valid    (cti_valid),
        .insn_compact (insn_compact),
        .err          (err)
    );

    assign fetch_addr   = pc_q;
    assign in_slot      = pend_q.valid;
    assign err_slot_cti = err.slot_cti;
    assign err_compact  = err.compact;
    assign err_align    = err.align;

endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
    parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
    input logic        clk,
    input logic        rst,
    input logic        fetch_ready,
    input logic        cti_valid,
    input logic        cti_taken,
    input logic        insn_compact,
    input logic [31:0] cti_target,
    input logic [31:0] fetch_addr,
    input logic        in_slot,
    input logic        err_slot_cti,
    input logic        err_compact,
    input logic        err_align
);

    logic [31:0] tgt_q;
    logic        tk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q <= '0;
            tk_q  <= 1'b0;
        end else if (fetch_ready && cti_valid && !in_slot) begin
            tgt_q <= cti_target;
            tk_q  <= cti_taken;
        end
    end

    // R1
    reset_vector_chk: assert property (@(posedge clk)
        rst |=> (fetch_addr == RESET_VEC) && !in_slot);

    // R2
    seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_ready && !in_slot |=> fetch_addr == $past(fetch_addr) + 32'd4);

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_ready |=> $stable(fetch_addr) && $stable(in_slot));

    // R3
    stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_ready |-> !err_slot_cti && !err_compact && !err_align);

    // R4
    shadow_follows_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_ready && cti_valid && !in_slot |=> in_slot);

    // R6
    single_shadow_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_ready && in_slot |=> !in_slot);

    // R5
    taken_target_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_ready && in_slot && tk_q |=> fetch_addr == {$past(tgt_q[31:2]), 2'b00});

    // R7
    slot_cti_chk: assert property (@(posedge clk) disable iff (rst)
        err_slot_cti |-> in_slot && cti_valid && fetch_ready);

    // R8
    compact_chk: assert property (@(posedge clk) disable iff (rst)
        err_compact |-> in_slot && insn_compact);

    // R9
    align_chk: assert property (@(posedge clk) disable iff (rst)
        err_align |-> in_slot && tk_q && (tgt_q[1:0] != 2'b00));

endmodule

bind pc_slot_seq pcseq_checker #(.RESET_VEC(RESET_VEC)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .fetch_ready  (fetch_ready),
    .cti_valid    (cti_valid),
    .cti_taken    (cti_taken),
    .insn_compact (insn_compact),
    .cti_target   (cti_target),
    .fetch_addr   (fetch_addr),
    .in_slot      (in_slot),
    .err_slot_cti (err_slot_cti),
    .err_compact  (err_compact),
    .err_align    (err_align)
);

// File: tb/pc_slot_seq_tb_top.sv
`timescale 1ns/1ps
module pc_slot_seq_tb_top;

    localparam logic [31:0] RV = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_ready = 1'b0;
    logic        cti_valid = 1'b0;
    logic        cti_taken = 1'b0;
    logic        cti_indirect = 1'b0;
    logic [31:0] cti_target = '0;
    logic        insn_compact = 1'b0;
    logic [31:0] fetch_addr;
    logic        in_slot;
    logic        err_slot_cti;
    logic        err_compact;
    logic        err_align;

    always #2 clk = ~clk;

    pc_slot_seq #(.RESET_VEC(RV)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .fetch_ready  (fetch_ready),
        .cti_valid    (cti_valid),
        .cti_taken    (cti_taken),
        .cti_indirect (cti_indirect),
        .cti_target   (cti_target),
        .insn_compact (insn_compact),
        .fetch_addr   (fetch_addr),
        .in_slot      (in_slot),
        .err_slot_cti (err_slot_cti),
        .err_compact  (err_compact),
        .err_align    (err_align)
    );

    typedef struct {
        logic [31:0] addr;
        logic        slot;
        logic        e_cti;
        logic        e_cmp;
        logic        e_al;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_run  = 0;
    int   n_fail = 0;

    // reference state derived from the requirements
    logic [31:0] m_pc;
    logic        m_pend, m_taken, m_ind;
    logic [31:0] m_tgt;

    task automatic compare(input exp_t e);
        n_run++;
        if (fetch_addr !== e.addr || in_slot !== e.slot || err_slot_cti !== e.e_cti ||
            err_compact !== e.e_cmp || err_align !== e.e_al) begin
            n_fail++;
            $display("FAIL %s: got addr=%h slot=%b cti=%b cmp=%b al=%b, expected addr=%h slot=%b cti=%b cmp=%b al=%b",
                     e.tag, fetch_addr, in_slot, err_slot_cti, err_compact, err_align,
                     e.addr, e.slot, e.e_cti, e.e_cmp, e.e_al);
        end
    endtask

    task automatic step(input logic rdy, input logic cti, input logic tk, input logic ind,
                        input logic cmp, input logic [31:0] tgt, input string tag);
        exp_t e;
        @(negedge clk);
        fetch_ready  = rdy;
        cti_valid    = cti;
        cti_taken    = tk;
        cti_indirect = ind;
        cti_target   = tgt;
        insn_compact = cmp;
        e.addr  = m_pc;
        e.slot  = m_pend;
        e.e_cti = rdy && m_pend && cti;
        e.e_cmp = rdy && m_pend && m_ind && cmp;
        e.e_al  = rdy && m_pend && m_taken && (m_tgt[1:0] != 2'b00);
        e.tag   = tag;
        exp_q.push_back(e);
        if (rdy) begin
            if (m_pend) begin
                m_pc   = m_taken ? {m_tgt[31:2], 2'b00} : m_pc + 32'd4;
                m_pend = 1'b0;
            end else begin
                if (cti) begin
                    m_pend  = 1'b1;
                    m_taken = tk;
                    m_ind   = ind;
                    m_tgt   = tgt;
                end
                m_pc = m_pc + 32'd4;
            end
        end
    endtask

    // monitor: compare in the low phase once inputs have settled
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) compare(exp_q.pop_front());
        end
    end

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        exp_t r;
        m_pc = RV; m_pend = 1'b0; m_taken = 1'b0; m_ind = 1'b0; m_tgt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        r.addr = RV; r.slot = 1'b0; r.e_cti = 1'b0; r.e_cmp = 1'b0; r.e_al = 1'b0; r.tag = "R1";
        compare(r);

        // R2: plain sequential flow
        step(1, 0, 0, 0, 0, 32'h0, "R2");
        step(1, 0, 0, 0, 0, 32'h0, "R2");
        step(1, 0, 0, 0, 0, 32'h0, "R2");

        // R4 R5 R6: taken jump to 0x2000
        step(1, 1, 1, 0, 0, 32'h0000_2000, "R2 cti");
        step(1, 0, 0, 0, 0, 32'h0, "R4 shadow");
        step(1, 0, 0, 0, 0, 32'h0, "R5 taken target / R6");
        step(1, 0, 0, 0, 0, 32'h0, "R6");

        // R5: not-taken branch continues in order
        step(1, 1, 0, 0, 0, 32'h0000_3000, "R2 cti");
        step(1, 0, 0, 0, 0, 32'h0, "R4 shadow");
        step(1, 0, 0, 0, 0, 32'h0, "R5 not taken");

        // R3: stall between transfer and shadow
        step(1, 1, 1, 0, 0, 32'h0000_5000, "R2 cti");
        step(0, 1, 0, 1, 1, 32'h0000_7777, "R3 stall");
        step(0, 0, 0, 0, 0, 32'h0, "R3 stall");
        step(1, 0, 0, 0, 0, 32'h0, "R3 R4 shadow after stall");
        step(0, 0, 0, 0, 0, 32'h0, "R3 R5 stall at target");
        step(1, 0, 0, 0, 0, 32'h0, "R5");

        // R7: transfer inside the shadow is flagged and ignored
        step(1, 1, 1, 0, 0, 32'h0000_6000, "R2 cti");
        step(1, 1, 1, 0, 0, 32'h0000_9000, "R7 cti in shadow");
        step(1, 0, 0, 0, 0, 32'h0, "R7 original target");
        step(1, 0, 0, 0, 0, 32'h0, "R7 no stale shadow");

        // R8: compact shadows
        step(1, 1, 1, 1, 0, 32'h0000_8000, "R2 indirect");
        step(1, 0, 0, 0, 1, 32'h0, "R8 compact in indirect shadow");
        step(1, 1, 1, 0, 0, 32'h0000_8100, "R2 direct");
        step(1, 0, 0, 0, 1, 32'h0, "R8 compact in direct shadow");
        step(1, 0, 0, 0, 1, 32'h0, "R8 compact outside shadow");

        // R9: target alignment
        step(1, 1, 1, 0, 0, 32'h0000_4002, "R2 cti");
        step(1, 0, 0, 0, 0, 32'h0, "R9 misaligned taken");
        step(1, 1, 0, 0, 0, 32'h0000_4101, "R5 floored target / cti");
        step(1, 0, 0, 0, 0, 32'h0, "R9 misaligned not taken");
        step(1, 0, 0, 0, 0, 32'h0, "R5");

        @(negedge clk);
        fetch_ready = 1'b0;
        cti_valid   = 1'b0;
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule